// File: doc/BRIEF.md
# Domain Idle Configuration Controller

The block decides which sub-domains of a processor clock domain receive a clock. Software first writes a wanted idle pattern into a staging register. Writing that register changes nothing by itself. An idle command strobe then commits the staged pattern into a live status register. Each set bit of the status register turns off the clock enable of one domain. When the processor domain itself is idled, a halt indication stops execution.

An unmasked interrupt immediately re-enables a fixed group of domains: the processor, the data port, the external port and the instruction port. The accelerator and memory-port domains ignore interrupts and stay idle until software commits a new pattern.

A pattern that idles the memory port is held back while a DMA engine is using on-chip memory. A pattern that idles the external port but keeps the processor running is rejected. The interrupt reaches the interrupt flag output a fixed number of cycles after the processor domain wakes.

Top module: `idle_domain_ctrl`

## Requirements
- R1: After reset the staged and status registers are zero. All ten clock enables are high. `halt_o`, `pending_o`, `err_o` and `irq_flag_o` are low.
- R2: A write stores `cfg_wdata_i` into the staged register, which reads back on `cfg_o` after the edge. A write alone changes neither `status_o` nor `clk_en_o`.
- R3: An accepted idle command copies the staged register into `status_o` at the same edge. `clk_en_o[i]` is the inverse of effective status bit i, so a set bit means the domain is idle.
- R4: `halt_o` is high exactly while bit 0 (the processor domain) is effectively idle.
- R5: While `irq_i` is high, status bits 0, 5, 6 and 8 read as active on `clk_en_o` and `halt_o` in the same cycle, with no clock edge needed. At the next edge those bits are cleared in `status_o`. This holds even when a commit happens at the same edge.
- R6: Bit 1 (memory port) and bit 2 (accelerator) are never changed by `irq_i`.
- R7: `irq_flag_o` follows `irq_i` with a delay of 3 clock cycles. The processor domain is always awake while `irq_i` is high.
- R8: A command whose staged pattern has bit 1 set while `dma_busy_i` is high does not commit. Instead it raises `pending_o` and holds the pattern staged at that moment. That pattern is committed at the first edge with `dma_busy_i` low, and `pending_o` then drops. A pattern without bit 1 commits at once regardless of `dma_busy_i`.
- R9: An idle command that arrives while `pending_o` is high is ignored. Later writes do not change the pattern that is being held.
- R10: A command whose staged pattern has bit 6 set and bit 0 clear is rejected. `status_o` keeps its value and `err_o` rises, and `err_o` stays high until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Staged register write strobe |
| cfg_wdata_i | input | 10 | Staged idle pattern |
| idle_cmd_i | input | 1 | One-cycle idle command |
| irq_i | input | 1 | Unmasked interrupt |
| dma_busy_i | input | 1 | A DMA engine is using on-chip memory |
| clk_en_o | output | 10 | Per-domain clock enable, high = running |
| halt_o | output | 1 | Processor domain idle, execution stops |
| irq_flag_o | output | 1 | Delayed interrupt flag |
| cfg_o | output | 10 | Staged register readback |
| status_o | output | 10 | Status register readback |
| pending_o | output | 1 | Commit waiting for DMA completion |
| err_o | output | 1 | Last command was rejected |

## Verification
The commit path is exercised with three kinds of pattern, each separating a different behaviour:
- A pattern with only the memory-port and accelerator bits set shows that a commit changes no halt state.
- A pattern that adds the four interrupt-wakeable bits separates the cleared bits from the sticky ones when an interrupt pulse arrives.
- A data-port-only pattern under DMA traffic shows that only the memory-port bit triggers waiting.

The DMA sequence also writes and commands again while a commit is pending, which proves that the held value and not the staged value is committed. An external-port-only pattern checks rejection and how long the error flag stays up. A commit and an interrupt in the same cycle check which one wins.

// File: rtl/idle_pkg.sv
package idle_pkg;
  localparam int unsigned N_DOM     = 10;
  localparam int unsigned CPU_BIT   = 0;
  localparam int unsigned MPORT_BIT = 1;
  localparam int unsigned HWA_BIT   = 2;
  localparam int unsigned DPORT_BIT = 5;
  localparam int unsigned XPORT_BIT = 6;
  localparam int unsigned IPORT_BIT = 8;
  localparam int unsigned IRQ_DLY   = 3;

  typedef logic [N_DOM-1:0] dom_vec_t;

  localparam dom_vec_t WAKE_MASK = N_DOM'((1 << CPU_BIT) | (1 << DPORT_BIT) |
                                          (1 << XPORT_BIT) | (1 << IPORT_BIT));

  function automatic logic cfg_valid(dom_vec_t c);
    return !(c[XPORT_BIT] && !c[CPU_BIT]);
  endfunction
endpackage

// File: rtl/idle_commit_ctrl.sv
module idle_commit_ctrl
  import idle_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cfg_we_i,
  input  dom_vec_t cfg_wdata_i,
  input  logic     idle_cmd_i,
  input  logic     dma_busy_i,
  output dom_vec_t cfg_o,
  output logic     commit_o,
  output dom_vec_t commit_val_o,
  output logic     pending_o,
  output logic     err_o
);
  dom_vec_t cfg_q, hold_q;
  logic     pend_q, err_q;
  logic     cmd_ok, valid, must_wait, drain;

  assign cmd_ok    = idle_cmd_i && !pend_q;
  assign valid     = cfg_valid(cfg_q);
  assign must_wait = cfg_q[MPORT_BIT] && dma_busy_i;
  assign drain     = pend_q && !dma_busy_i;

  assign commit_o     = drain || (cmd_ok && valid && !must_wait);
  assign commit_val_o = pend_q ? hold_q : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_wdata_i;
      if (cmd_ok && !valid)  err_q <= 1'b1;
      else if (cfg_we_i)     err_q <= 1'b0;
      if (cmd_ok && valid && must_wait) begin
        pend_q <= 1'b1;
        hold_q <= cfg_q;
      end else if (drain) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign cfg_o     = cfg_q;
  assign pending_o = pend_q;
  assign err_o     = err_q;
endmodule

// File: rtl/idle_status_reg.sv
module idle_status_reg
  import idle_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     commit_i,
  input  dom_vec_t commit_val_i,
  input  logic     irq_i,
  output dom_vec_t status_o,
  output dom_vec_t clk_en_o,
  output logic     halt_o
);
  dom_vec_t status_q, wake, eff;

  // interrupt wake path bypasses the flop so enables return without an edge
  assign wake = irq_i ? WAKE_MASK : '0;
  assign eff  = status_q & ~wake;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (commit_i ? commit_val_i : status_q) & ~wake;
  end

  assign status_o = status_q;
  assign clk_en_o = ~eff;
  assign halt_o   = eff[CPU_BIT];
endmodule

// File: rtl/irq_flag_delay.sv
module irq_flag_delay #(
  parameter int unsigned DLY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic cpu_en_i,
  output logic flag_o
);
  logic [DLY-1:0] sh_q;
  logic           in_d;

  assign in_d = irq_i && cpu_en_i;

  generate
    if (DLY == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= in_d;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[DLY-2:0], in_d};
      end
    end
  endgenerate

  assign flag_o = sh_q[DLY-1];
endmodule

// File: rtl/idle_domain_ctrl.sv
module idle_domain_ctrl
  import idle_pkg::*;
#(
  parameter int unsigned IRQ_DLY_P = IRQ_DLY
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [N_DOM-1:0] cfg_wdata_i,
  input  logic             idle_cmd_i,
  input  logic             irq_i,
  input  logic             dma_busy_i,
  output logic [N_DOM-1:0] clk_en_o,
  output logic             halt_o,
  output logic             irq_flag_o,
  output logic [N_DOM-1:0] cfg_o,
  output logic [N_DOM-1:0] status_o,
  output logic             pending_o,
  output logic             err_o
);
  logic     commit;
  dom_vec_t commit_val;

  idle_commit_ctrl u_commit (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_we_i     (cfg_we_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .idle_cmd_i   (idle_cmd_i),
    .dma_busy_i   (dma_busy_i),
    .cfg_o        (cfg_o),
    .commit_o     (commit),
    .commit_val_o (commit_val),
    .pending_o    (pending_o),
    .err_o        (err_o)
  );

  idle_status_reg u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit),
    .commit_val_i (commit_val),
    .irq_i        (irq_i),
    .status_o     (status_o),
    .clk_en_o     (clk_en_o),
    .halt_o       (halt_o)
  );

  irq_flag_delay #(.DLY(IRQ_DLY_P)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_i    (irq_i),
    .cpu_en_i (clk_en_o[CPU_BIT]),
    .flag_o   (irq_flag_o)
  );
endmodule

// File: rtl/idle_domain_ctrl_chk.sv
module idle_domain_ctrl_chk
  import idle_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             idle_cmd_i,
  input logic             irq_i,
  input logic             dma_busy_i,
  input logic [N_DOM-1:0] clk_en_o,
  input logic             halt_o,
  input logic             irq_flag_o,
  input logic [N_DOM-1:0] cfg_o,
  input logic [N_DOM-1:0] status_o,
  input logic             pending_o,
  input logic             err_o
);
  AST_WRITE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && !idle_cmd_i && !pending_o && !irq_i |=> $stable(status_o)); // R2

  AST_COMMIT_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_cmd_i && !pending_o && cfg_valid(cfg_o) && !(cfg_o[MPORT_BIT] && dma_busy_i) && !irq_i
    |=> status_o == $past(cfg_o)); // R3

  AST_HALT_CPU_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[CPU_BIT] && !irq_i |-> halt_o && !clk_en_o[CPU_BIT]); // R4

  AST_IRQ_WAKES_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> !halt_o && clk_en_o[DPORT_BIT] && clk_en_o[XPORT_BIT] && clk_en_o[IPORT_BIT]); // R5

  AST_IRQ_CLEARS_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> (status_o & WAKE_MASK) == '0); // R5

  AST_STICKY_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i && !idle_cmd_i && !pending_o
    |=> $stable(status_o[MPORT_BIT]) && $stable(status_o[HWA_BIT])); // R6

  generate
    if (IRQ_DLY == 3) begin : g_dly
      AST_IRQ_FLAG_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_flag_o |-> $past(irq_i, 3)); // R7
    end
  endgenerate

  AST_DMA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o && dma_busy_i && !irq_i |=> $stable(status_o)); // R8

  AST_PEND_IGNORES_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o && dma_busy_i |=> pending_o); // R9

  AST_INVALID_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_cmd_i && !pending_o && !cfg_valid(cfg_o) && !irq_i
    |=> $stable(status_o) && err_o); // R10
endmodule

bind idle_domain_ctrl idle_domain_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .idle_cmd_i (idle_cmd_i),
  .irq_i      (irq_i),
  .dma_busy_i (dma_busy_i),
  .clk_en_o   (clk_en_o),
  .halt_o     (halt_o),
  .irq_flag_o (irq_flag_o),
  .cfg_o      (cfg_o),
  .status_o   (status_o),
  .pending_o  (pending_o),
  .err_o      (err_o)
);

// File: tb/idle_domain_ctrl_test.sv
`timescale 1ns/1ps
module idle_domain_ctrl_test;
  import idle_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, cmd = 1'b0, irq = 1'b0, dma = 1'b0;
  logic [N_DOM-1:0] wd = '0;
  logic [N_DOM-1:0] clk_en, cfg_rb, status;
  logic halt, flag, pending, err;

  always #5 clk = ~clk;

  idle_domain_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wd),
    .idle_cmd_i(cmd), .irq_i(irq), .dma_busy_i(dma),
    .clk_en_o(clk_en), .halt_o(halt), .irq_flag_o(flag), .cfg_o(cfg_rb),
    .status_o(status), .pending_o(pending), .err_o(err)
  );

  typedef enum int {F_STAT, F_EN, F_HALT, F_PEND, F_ERR, F_FLAG, F_CFG} field_e;
  typedef struct {string req; field_e f; int unsigned exp;} item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic int unsigned actual(field_e f);
    case (f)
      F_STAT:  return int'(status);
      F_EN:    return int'(clk_en);
      F_HALT:  return int'(halt);
      F_PEND:  return int'(pending);
      F_ERR:   return int'(err);
      F_FLAG:  return int'(flag);
      default: return int'(cfg_rb);
    endcase
  endfunction

  function automatic void compare(item_t it);
    int unsigned a;
    a = actual(it.f);
    checks++;
    if (a !== it.exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", it.req, it.f.name(), a, it.exp);
    end
  endfunction

  task automatic expect_next(string req, field_e f, int unsigned e);
    item_t it;
    it.req = req; it.f = f; it.exp = e;
    q.push_back(it);
  endtask

  // monitor: pop expectations once the driven edge has passed
  initial forever begin
    @(negedge clk); #1;
    while (q.size() > 0) compare(q.pop_front());
  end

  task automatic cyc(bit w, int unsigned d, bit c, bit i, bit b);
    @(negedge clk); #2;
    we = w; wd = N_DOM'(d); cmd = c; irq = i; dma = b;
  endtask

  localparam int unsigned ALL = (1 << N_DOM) - 1;

  task automatic run_all();
    item_t now;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0);
    expect_next("R1", F_STAT, 0); expect_next("R1", F_EN, ALL);
    expect_next("R1", F_HALT, 0); expect_next("R1", F_PEND, 0);
    expect_next("R1", F_ERR, 0);  expect_next("R1", F_CFG, 0);
    expect_next("R1", F_FLAG, 0);

    cyc(1, 'h006, 0, 0, 0);
    expect_next("R2", F_CFG, 'h006); expect_next("R2", F_STAT, 0); expect_next("R2", F_EN, ALL);

    cyc(0, 0, 1, 0, 0);
    expect_next("R3", F_STAT, 'h006); expect_next("R3", F_EN, ALL & ~'h006);
    expect_next("R4", F_HALT, 0);

    cyc(1, 'h167, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    expect_next("R3", F_STAT, 'h167); expect_next("R3", F_EN, ALL & ~'h167);
    expect_next("R4", F_HALT, 1);

    // interrupt pulse: immediate wake, then sticky bits remain
    cyc(0, 0, 0, 1, 0);
    #1;
    now.req = "R5"; now.f = F_EN;   now.exp = ALL & ~'h006; compare(now);
    now.req = "R5"; now.f = F_HALT; now.exp = 0;            compare(now);
    expect_next("R6", F_STAT, 'h006); expect_next("R7", F_FLAG, 0);
    cyc(0, 0, 0, 0, 0); expect_next("R7", F_FLAG, 0);
    cyc(0, 0, 0, 0, 0); expect_next("R7", F_FLAG, 1);
    cyc(0, 0, 0, 0, 0); expect_next("R7", F_FLAG, 0);

    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0); expect_next("R3", F_STAT, 0);

    // DMA hold-off with a later write and ignored command
    cyc(1, 'h002, 0, 0, 1);
    cyc(0, 0, 1, 0, 1); expect_next("R8", F_PEND, 1); expect_next("R8", F_STAT, 0);
    cyc(1, 'h004, 0, 0, 1); expect_next("R9", F_STAT, 0);
    cyc(0, 0, 1, 0, 1); expect_next("R9", F_PEND, 1); expect_next("R9", F_STAT, 0);
    cyc(0, 0, 0, 0, 0); expect_next("R8", F_STAT, 'h002); expect_next("R8", F_PEND, 0);

    // pattern without memory port commits despite DMA
    cyc(1, 'h020, 0, 0, 1);
    cyc(0, 0, 1, 0, 1); expect_next("R8", F_STAT, 'h020); expect_next("R8", F_PEND, 0);

    // invalid: external port idle with processor running
    cyc(1, 'h040, 0, 0, 0);
    cyc(0, 0, 1, 0, 0); expect_next("R10", F_STAT, 'h020); expect_next("R10", F_ERR, 1);
    cyc(0, 0, 0, 0, 0); expect_next("R10", F_ERR, 1);
    cyc(1, 0, 0, 0, 0); expect_next("R10", F_ERR, 0);

    // commit and interrupt at the same edge
    cyc(1, 'h163, 0, 0, 0);
    cyc(0, 0, 1, 1, 0); expect_next("R5", F_STAT, 'h002); expect_next("R6", F_EN, ALL & ~'h002);
    cyc(0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      begin run_all(); done = 1; end
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin errors++; $display("FAIL watchdog expired"); end
      end
    join_any
    #3;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule